// File: doc/BRIEF.md
# PS/2 Key Matrix Emulator

This block turns the serial scan-code stream of a PS/2 keyboard into the state of a scanned key matrix of 16 columns by 8 rows. Host logic written for a column/row keyboard uses it unchanged. The host picks a column and a row and reads whether that key is held. It can also let the block step the column on its own from a 1 MHz tick, so that the matrix is swept.

The PS/2 receiver checks each frame. The release prefix and the extended prefix are tracked across bytes. A small lookup then turns each code into a matrix position. One key sits outside the matrix and drives its own break output. Row 0 of eight columns reads eight configuration switches, so software sees them as keys. An interrupt flag is raised whenever a key in rows 1 to 7 is held. The only reset is the hard reset, so pulling the break output into a system reset leaves the held-key state intact.

Top module: `keymatrix_ps2`

## Requirements
- R1: After hard reset, every non-switch position reads as up, anyKey and breakKey are 0, and scanCol is 0.
- R2: A frame is 11 bits sampled on falling edges of ps2Clk: a 0 start bit, 8 data bits with the LSB first, an odd parity bit, and a 1 stop bit. A valid frame carrying a mapped code marks that key held.
- R3: A frame with wrong parity or a 0 stop bit is discarded and changes no key.
- R4: The byte F0 makes the next code a release, and that key then reads as up.
- R5: The byte E0 makes the next code use the extended table. Plain 75 is column 12 row 2, while E0 75 is column 9 row 3.
- R6: Plain codes map as (column,row): 12→(0,0), 14→(1,0), 1C→(1,4), 1B→(1,5), 29→(2,6), 5A→(9,4), 76→(0,7). Extended 6B maps to (9,1).
- R7: Switch input bit i reads as the row 0 key of column 2+i, and a 1 reads as down.
- R8: anyKey is 1 exactly when some key in rows 1 to 7 is held. Row 0 keys and switches never raise it.
- R9: Plain code 09 drives breakKey, which is 1 while that key is held. It occupies no matrix position, does not affect anyKey, and does not clear held keys.
- R10: With autoScan 0, scanCol takes colSel one cycle later, and keyDown shows the key at (scanCol,rowSel).
- R11: With autoScan 1, scanCol advances by one, modulo 16, in each cycle with tick1us high, and holds in every other cycle.
- R12: Codes that are not mapped, including extended codes that are not mapped, change no key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| tick1us | input | 1 | 1 MHz column-step enable |
| ps2Clk | input | 1 | PS/2 clock line (asynchronous) |
| ps2Data | input | 1 | PS/2 data line (asynchronous) |
| autoScan | input | 1 | 1 = column counter free-runs on tick1us |
| colSel | input | 4 | Host column select |
| rowSel | input | 3 | Host row select |
| dipSw | input | 8 | Switches shown as row 0 keys |
| keyDown | output | 1 | Selected key is held |
| anyKey | output | 1 | A key in rows 1 to 7 is held |
| breakKey | output | 1 | Break key is held |
| scanCol | output | 4 | Current column counter value |

## Verification
On every cycle, the assertions check how the column counter behaves in both modes. They also check that anyKey and breakKey change only in the cycle after a decoded key event from the receiver. Correct decoding, which includes parity and framing rejection, the prefix handling, the key map and the switch placement, can only be seen through the bench scenarios. After each scenario the bench sweeps all 128 matrix positions against its own model.

// File: rtl/keymatrix_pkg.sv
package keymatrix_pkg;
  localparam int COL_W      = 4;
  localparam int ROW_W      = 3;
  localparam int NUM_COLS   = 1 << COL_W;
  localparam int NUM_ROWS   = 1 << ROW_W;
  localparam int DIP_W      = 8;
  localparam int DIP_COL0   = 2;
  localparam int CODE_W     = 8;
  localparam int FRAME_BITS = 11;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CODE_W-1:0] CODE_UP  = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_EXT = 8'hE0;

  // strobe from receiver control to matrix datapath
  typedef struct packed {
    logic              keyEvt;
    logic              isUp;
    logic              extended;
    logic [CODE_W-1:0] code;
  } keyStrobe_t;

  typedef struct packed {
    logic             hit;
    logic             isBreak;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
  } keyPos_t;

  function automatic keyPos_t mk(input int c, input int r, input logic brk);
    keyPos_t p;
    p.hit     = 1'b1;
    p.isBreak = brk;
    p.col     = COL_W'(c);
    p.row     = ROW_W'(r);
    return p;
  endfunction

  function automatic keyPos_t lookupKey(input logic ext, input logic [CODE_W-1:0] code);
    keyPos_t p;
    p = '0;
    if (ext) begin
      case (code)
        8'h75:   p = mk(9, 3, 1'b0);
        8'h6B:   p = mk(9, 1, 1'b0);
        default: p = '0;
      endcase
    end else begin
      case (code)
        8'h12:   p = mk(0, 0, 1'b0);
        8'h14:   p = mk(1, 0, 1'b0);
        8'h1C:   p = mk(1, 4, 1'b0);
        8'h1B:   p = mk(1, 5, 1'b0);
        8'h29:   p = mk(2, 6, 1'b0);
        8'h5A:   p = mk(9, 4, 1'b0);
        8'h76:   p = mk(0, 7, 1'b0);
        8'h75:   p = mk(12, 2, 1'b0);
        8'h09:   p = mk(0, 0, 1'b1);
        default: p = '0;
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/keymatrix_ctrl.sv
module keymatrix_ctrl
  import keymatrix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2Clk,
  input  logic       ps2Data,
  output keyStrobe_t keyStb
);
  logic [1:0]            clkSync, datSync;
  logic                  clkPrev;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] frameSr, nextSr;
  logic                  upPend, extPend;
  logic                  fallEdge, lastBit, frameOk, idleBit;
  logic [CODE_W-1:0]     rxByte;

  assign fallEdge = clkPrev & ~clkSync[1];
  assign nextSr   = {datSync[1], frameSr[FRAME_BITS-1:1]};
  assign idleBit  = (bitCnt == '0) && datSync[1];
  assign lastBit  = fallEdge && (bitCnt == CNT_W'(FRAME_BITS - 1));
  // start low, stop high, odd parity over data plus parity bit
  assign frameOk  = !nextSr[0] && nextSr[FRAME_BITS-1] && (^nextSr[CODE_W+1:1]);
  assign rxByte   = nextSr[CODE_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '1;
      datSync <= '1;
      clkPrev <= 1'b1;
      bitCnt  <= '0;
      frameSr <= '0;
      upPend  <= 1'b0;
      extPend <= 1'b0;
      keyStb  <= '0;
    end else begin
      clkSync       <= {clkSync[0], ps2Clk};
      datSync       <= {datSync[0], ps2Data};
      clkPrev       <= clkSync[1];
      keyStb.keyEvt <= 1'b0;
      if (fallEdge && !idleBit) begin
        frameSr <= nextSr;
        bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
        if (lastBit && frameOk) begin
          if (rxByte == CODE_UP) begin
            upPend <= 1'b1;
          end else if (rxByte == CODE_EXT) begin
            extPend <= 1'b1;
          end else begin
            keyStb.keyEvt   <= 1'b1;
            keyStb.isUp     <= upPend;
            keyStb.extended <= extPend;
            keyStb.code     <= rxByte;
            upPend          <= 1'b0;
            extPend         <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keymatrix_dp.sv
module keymatrix_dp
  import keymatrix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1us,
  input  logic             autoScan,
  input  logic [COL_W-1:0] colSel,
  input  logic [ROW_W-1:0] rowSel,
  input  logic [DIP_W-1:0] dipSw,
  input  keyStrobe_t       keyStb,
  output logic             keyDown,
  output logic             anyKey,
  output logic             breakKey,
  output logic [COL_W-1:0] scanCol
);
  logic [NUM_COLS-1:0][NUM_ROWS-1:0] keyMat, colView;
  logic [NUM_COLS-1:0]               colHigh;
  logic [COL_W-1:0]                  colCnt;
  logic                              breakReg;
  keyPos_t                           pos;

  assign pos = lookupKey(keyStb.extended, keyStb.code);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyMat   <= '0;
      breakReg <= 1'b0;
      colCnt   <= '0;
    end else begin
      if (autoScan) begin
        if (tick1us) colCnt <= colCnt + 1'b1;
      end else begin
        colCnt <= colSel;
      end
      if (keyStb.keyEvt && pos.hit) begin
        if (pos.isBreak) breakReg <= !keyStb.isUp;
        else             keyMat[pos.col][pos.row] <= !keyStb.isUp;
      end
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    if (c >= DIP_COL0 && c < DIP_COL0 + DIP_W) begin : g_dip
      assign colView[c] = {keyMat[c][NUM_ROWS-1:1], dipSw[c-DIP_COL0]};
    end else begin : g_key
      assign colView[c] = keyMat[c];
    end
    assign colHigh[c] = |keyMat[c][NUM_ROWS-1:1];
  end

  assign keyDown  = colView[colCnt][rowSel];
  assign anyKey   = |colHigh;
  assign breakKey = breakReg;
  assign scanCol  = colCnt;
endmodule

// File: rtl/keymatrix_ps2.sv
module keymatrix_ps2
  import keymatrix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1us,
  input  logic             ps2Clk,
  input  logic             ps2Data,
  input  logic             autoScan,
  input  logic [COL_W-1:0] colSel,
  input  logic [ROW_W-1:0] rowSel,
  input  logic [DIP_W-1:0] dipSw,
  output logic             keyDown,
  output logic             anyKey,
  output logic             breakKey,
  output logic [COL_W-1:0] scanCol
);
  keyStrobe_t keyStb;

  keymatrix_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ps2Clk(ps2Clk), .ps2Data(ps2Data), .keyStb(keyStb)
  );

  keymatrix_dp u_dp (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .autoScan(autoScan),
    .colSel(colSel), .rowSel(rowSel), .dipSw(dipSw), .keyStb(keyStb),
    .keyDown(keyDown), .anyKey(anyKey), .breakKey(breakKey), .scanCol(scanCol)
  );
endmodule

// File: rtl/keymatrix_checker.sv
module keymatrix_checker
  import keymatrix_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tick1us,
  input logic             autoScan,
  input logic [COL_W-1:0] colSel,
  input logic [COL_W-1:0] scanCol,
  input logic             anyKey,
  input logic             breakKey,
  input keyStrobe_t       keyStb
);
  p_col_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !autoScan |=> scanCol == $past(colSel));

  p_scan_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (autoScan && tick1us) |=> scanCol == $past(scanCol) + 1'b1);

  p_scan_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (autoScan && !tick1us) |=> $stable(scanCol));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(anyKey) |-> $past(keyStb.keyEvt));

  p_break_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(breakKey) |-> $past(keyStb.keyEvt));
endmodule

bind keymatrix_ps2 keymatrix_checker u_chk (
  .clk(clk), .rstN(rstN), .tick1us(tick1us), .autoScan(autoScan),
  .colSel(colSel), .scanCol(scanCol), .anyKey(anyKey), .breakKey(breakKey),
  .keyStb(keyStb)
);

// File: tb/keymatrix_ps2_bench.sv
module keymatrix_ps2_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1us = 1'b0;
  logic ps2Clk = 1'b1;
  logic ps2Data = 1'b1;
  logic autoScan = 1'b0;
  logic [3:0] colSel = '0;
  logic [2:0] rowSel = '0;
  logic [7:0] dipSw = 8'hA5;
  logic keyDown, anyKey, breakKey;
  logic [3:0] scanCol;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0][7:0] mdl = '0;
  logic mdlBrk = 1'b0;

  always #4 clk = ~clk;

  keymatrix_ps2 u_keymatrix_ps2 (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .ps2Clk(ps2Clk), .ps2Data(ps2Data),
    .autoScan(autoScan), .colSel(colSel), .rowSel(rowSel), .dipSw(dipSw),
    .keyDown(keyDown), .anyKey(anyKey), .breakKey(breakKey), .scanCol(scanCol)
  );

  task automatic check(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // bench-side key map from R5, R6, R9
  task automatic applyModel(input bit ext, input bit up, input logic [7:0] code);
    int c, r;
    bit hit, brk;
    hit = 1; brk = 0; c = 0; r = 0;
    if (ext) begin
      case (code)
        8'h75: begin c = 9; r = 3; end
        8'h6B: begin c = 9; r = 1; end
        default: hit = 0;
      endcase
    end else begin
      case (code)
        8'h12: begin c = 0; r = 0; end
        8'h14: begin c = 1; r = 0; end
        8'h1C: begin c = 1; r = 4; end
        8'h1B: begin c = 1; r = 5; end
        8'h29: begin c = 2; r = 6; end
        8'h5A: begin c = 9; r = 4; end
        8'h76: begin c = 0; r = 7; end
        8'h75: begin c = 12; r = 2; end
        8'h09: brk = 1;
        default: hit = 0;
      endcase
    end
    if (hit && brk) mdlBrk = !up;
    else if (hit) mdl[c][r] = !up;
  endtask

  function automatic bit expView(input int c, input int r);
    if (r == 0 && c >= 2 && c <= 9) return dipSw[c-2];
    return mdl[c][r];
  endfunction

  function automatic bit expAny();
    bit a = 0;
    for (int c = 0; c < 16; c++) a |= |mdl[c][7:1];
    return a;
  endfunction

  task automatic sendFrame(input logic [7:0] b, input bit badPar, input bit badStop);
    logic [10:0] bits;
    bits = {~badStop, (~^b) ^ badPar, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      ps2Data = bits[i];
      repeat (6) @(negedge clk);
      ps2Clk = 1'b0;
      repeat (10) @(negedge clk);
      ps2Clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ps2Data = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic press(input bit ext, input logic [7:0] code);
    if (ext) sendFrame(8'hE0, 0, 0);
    sendFrame(code, 0, 0);
    applyModel(ext, 0, code);
  endtask

  task automatic unpress(input bit ext, input logic [7:0] code);
    if (ext) sendFrame(8'hE0, 0, 0);
    sendFrame(8'hF0, 0, 0);
    sendFrame(code, 0, 0);
    applyModel(ext, 1, code);
  endtask

  // full matrix sweep in manual mode (R10 path)
  task automatic sweep(input string tag);
    autoScan = 1'b0;
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 8; r++) begin
        colSel = 4'(c);
        rowSel = 3'(r);
        @(negedge clk);
        check(int'(keyDown), int'(expView(c, r)), tag, $sformatf("key c%0d r%0d", c, r));
      end
    end
    check(int'(scanCol), 15, "R10", "scanCol follows colSel");
    check(int'(anyKey), int'(expAny()), tag, "anyKey");
    check(int'(breakKey), int'(mdlBrk), tag, "breakKey");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state, R7 switch placement
    check(int'(anyKey), 0, "R1", "anyKey in reset");
    check(int'(breakKey), 0, "R1", "breakKey in reset");
    check(int'(scanCol), 0, "R1", "scanCol in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    sweep("R1");

    // R2 valid frame, R6 map, R8 interrupt
    press(0, 8'h1C);
    sweep("R2");
    check(int'(anyKey), 1, "R8", "row4 key raises anyKey");

    // R8 row 0 key held, row4 released: R4
    press(0, 8'h12);
    unpress(0, 8'h1C);
    sweep("R4");
    check(int'(anyKey), 0, "R8", "only row0 key held");

    // R3 bad parity and bad stop
    sendFrame(8'h29, 1, 0);
    sweep("R3");
    sendFrame(8'h29, 0, 1);
    sweep("R3");
    // receiver still works after rejects
    press(0, 8'h29);
    sweep("R6");

    // R5 plain vs extended 75
    press(0, 8'h75);
    sweep("R5");
    press(1, 8'h75);
    press(1, 8'h6B);
    sweep("R5");
    unpress(0, 8'h75);
    sweep("R5");

    // R6 remaining codes
    press(0, 8'h14);
    press(0, 8'h1B);
    press(0, 8'h5A);
    press(0, 8'h76);
    sweep("R6");

    // R9 break key
    press(0, 8'h09);
    sweep("R9");
    check(int'(breakKey), 1, "R9", "break held");
    unpress(0, 8'h09);
    sweep("R9");
    check(int'(breakKey), 0, "R9", "break released");

    // R12 unmapped codes, plain and extended
    press(0, 8'h33);
    press(1, 8'h12);
    unpress(1, 8'h1C);
    sweep("R12");

    // release everything, R4 / R8
    unpress(0, 8'h12); unpress(0, 8'h14); unpress(0, 8'h1B);
    unpress(0, 8'h29); unpress(0, 8'h5A); unpress(0, 8'h76);
    unpress(1, 8'h75); unpress(1, 8'h6B);
    sweep("R8");
    check(int'(anyKey), 0, "R8", "all released");

    // R7 switch pattern change
    dipSw = 8'h3C;
    sweep("R7");
    dipSw = 8'hFF;
    sweep("R7");

    // R11 autoscan stepping with wrap, and holding
    colSel = 4'd13;
    @(negedge clk);
    autoScan = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick1us = 1'b1;
      @(negedge clk);
      tick1us = 1'b0;
      check(int'(scanCol), (13 + i + 1) % 16, "R11", "step");
      @(negedge clk);
      check(int'(scanCol), (13 + i + 1) % 16, "R11", "hold");
    end
    colSel = 4'd2;
    repeat (3) @(negedge clk);
    check(int'(scanCol), (13 + 20) % 16, "R11", "ignores colSel");

    // R10 back to manual
    autoScan = 1'b0;
    colSel = 4'd6;
    @(negedge clk);
    check(int'(scanCol), 6, "R10", "manual reload");

    done = 1;
    summary();
    $finish;
  end
endmodule